// File: doc/BRIEF.md
# Sound Generator Register Bus Interface

This block is the host-facing register file of a three-channel programmable sound generator. A host reaches it over one 8-bit bidirectional bus, shown here as separate input, output and output-enable signals. Two control wires set the bus state: idle, read, write or address latch. An active-low reset clears everything. The host first latches a register number during one bus state. Later bus states read or write that register, and the latched number stays in place between accesses.

The fourteen byte registers are presented side by side on a flat output vector for the tone engine that follows. Register k occupies bits [8k+7:8k]. Some registers have fixed meanings: register 4 is the fine period of tone channel C, register 5 is its coarse period, register 7 holds the mixer enables, and register 10 is the amplitude of channel C. For example, 0x38 in register 7 turns off noise on every channel and turns on tone on A, B and C. This block only stores these values. It does not act on them.

Top module: `psg_regbus`

## Requirements
- R1: While rstN is low, all fourteen registers read 0, the latched register number is 0 and dataOe is low. After rstN is released, a write issued without a new latch lands in register 0.
- R2: The bus state is decoded from {busDir, busCtl}: 00 is idle, 01 is read, 10 is write and 11 is latch. In latch state, dataIn[3:0] becomes the current register number. It stays in place through any number of later idle, read or write cycles.
- R3: A latch cycle whose dataIn[7:4] is not zero is ignored, and the previous register number is kept.
- R4: On a clock edge where the state is write and the current register number is below 14, dataIn is stored in that register. The value shows in regImage[8k+7:8k] after that edge.
- R5: Several write cycles with no latch between them all go to the same register, and the last value written is kept.
- R6: dataOe is high only in read state. It is low in idle, write and latch states.
- R7: In read state, dataOut shows the current register's contents in the same cycle. A register not written since reset reads 0.
- R8: Register numbers 14 and 15 can be latched, but a write to them changes no register, and a read from them returns 0.
- R9: A write changes only the addressed register. All other register bytes in regImage keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busDir | input | 1 | Bus state code, upper bit |
| busCtl | input | 1 | Bus state code, lower bit |
| dataIn | input | 8 | Bus value driven by the host (register number or data) |
| dataOut | output | 8 | Bus value driven by the block during a read |
| dataOe | output | 1 | High while the block drives the bus |
| regImage | output | 112 | All fourteen registers, register k at bits [8k+7:8k] |

## Verification
The bench programs the mixer, amplitude and channel C period registers through the full write sequence. It then reads back all fourteen registers and compares them against a model. A design that drops the held register number, or that resets it on every idle cycle, would send repeated writes to the wrong place. Several targeted cases cover the remaining faults:
- A latch value with a non-zero upper nibble must leave the old register number in place. A design that takes only the low nibble would move the number instead.
- Numbers 14 and 15 must write nowhere and read as zero. A design that wraps or aliases them would corrupt a real register.
- Output-enable is sampled in every bus state. A design that drives the bus outside read state would show up there.
- A reset in the middle of a run must clear both the registers and the held register number.

// File: rtl/psg_regbus_pkg.sv
package psg_regbus_pkg;

  // Bus state as {busDir, busCtl}
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'b00,
    BUS_READ  = 2'b01,
    BUS_WRITE = 2'b10,
    BUS_LATCH = 2'b11
  } busCode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic wrData;
    logic rdData;
  } busStrobe_t;

endpackage

// File: rtl/psg_bus_ctrl.sv
module psg_bus_ctrl
  import psg_regbus_pkg::*;
(
  input  logic       rstN,
  input  logic       busDir,
  input  logic       busCtl,
  output busStrobe_t strobe
);

  busCode_e code;

  assign code = busCode_e'({busDir, busCtl});

  always_comb begin
    strobe = '0;
    if (rstN) begin
      unique case (code)
        BUS_LATCH: strobe.latchAddr = 1'b1;
        BUS_WRITE: strobe.wrData    = 1'b1;
        BUS_READ:  strobe.rdData    = 1'b1;
        default:   strobe           = '0;
      endcase
    end
  end

endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank
  import psg_regbus_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 14,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  busStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          dataIn,
  output logic [DATA_W-1:0]          dataOut,
  output logic                       dataOe,
  output logic [ADDR_W-1:0]          curAddr,
  output logic [DATA_W*NUM_REGS-1:0] regImage
);

  localparam int IMG_W  = DATA_W * NUM_REGS;
  localparam int HIGH_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic              latchOk;
  logic              addrInRange;
  logic [DATA_W-1:0] rdVal;

  // Upper address bits must be clear for a latch to take effect
  generate
    if (HIGH_W > 0) begin : g_highChk
      assign latchOk = (dataIn[DATA_W-1:ADDR_W] == '0);
    end else begin : g_noHigh
      assign latchOk = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.latchAddr && latchOk) begin
      addrQ <= dataIn[ADDR_W-1:0];
    end
  end

  assign addrInRange = ({1'b0, addrQ} < (ADDR_W+1)'(NUM_REGS));
  assign curAddr     = addrQ;

  // One storage byte per register
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] valQ;
      logic              hit;

      assign hit = strobe.wrData && (addrQ == ADDR_W'(g));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          valQ <= '0;
        end else if (hit) begin
          valQ <= dataIn;
        end
      end

      assign regImage[g*DATA_W +: DATA_W] = valQ;
    end
  endgenerate

  // Read selection
  always_comb begin
    rdVal = '0;
    if (addrInRange) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (addrQ == ADDR_W'(k)) begin
          rdVal = regImage[k*DATA_W +: DATA_W];
        end
      end
    end
  end

  assign dataOut = strobe.rdData ? rdVal : '0;
  assign dataOe  = strobe.rdData;

  logic unusedImg;
  assign unusedImg = ^regImage[IMG_W-1:0] & 1'b0;

endmodule

// File: rtl/psg_regbus.sv
module psg_regbus
  import psg_regbus_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 14,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busDir,
  input  logic                       busCtl,
  input  logic [DATA_W-1:0]          dataIn,
  output logic [DATA_W-1:0]          dataOut,
  output logic                       dataOe,
  output logic [DATA_W*NUM_REGS-1:0] regImage
);

  busStrobe_t        strobe;
  logic [ADDR_W-1:0] curAddr;

  psg_bus_ctrl ctrl_i (
    .rstN   (rstN),
    .busDir (busDir),
    .busCtl (busCtl),
    .strobe (strobe)
  );

  psg_reg_bank #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) bank_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataOe   (dataOe),
    .curAddr  (curAddr),
    .regImage (regImage)
  );

endmodule

// File: rtl/psg_regbus_chk.sv
module psg_regbus_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 14,
  parameter int ADDR_W   = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busDir,
  input logic                       busCtl,
  input logic [DATA_W-1:0]          dataIn,
  input logic [DATA_W-1:0]          dataOut,
  input logic                       dataOe,
  input logic [ADDR_W-1:0]          curAddr,
  input logic [DATA_W*NUM_REGS-1:0] regImage
);

  logic              wrValidQ;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] landed;
  logic              inRange;
  logic              latchHigh;

  assign inRange   = ({1'b0, curAddr} < (ADDR_W+1)'(NUM_REGS));
  assign latchHigh = busDir && busCtl && (dataIn[DATA_W-1:ADDR_W] != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValidQ <= 1'b0;
      wrAddrQ  <= '0;
      wrDataQ  <= '0;
    end else begin
      wrValidQ <= busDir && !busCtl && inRange;
      wrAddrQ  <= curAddr;
      wrDataQ  <= dataIn;
    end
  end

  always_comb begin
    landed = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (wrAddrQ == ADDR_W'(k)) landed = regImage[k*DATA_W +: DATA_W];
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |-> (regImage == '0 && curAddr == '0 && !dataOe));

  assert_bad_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    latchHigh |=> $stable(curAddr));

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrValidQ |-> (landed == wrDataQ));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busDir && busCtl) |=> $stable(curAddr));

  assert_oe_read_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!busDir && busCtl));

  assert_high_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busDir && !busCtl && !inRange) |=> $stable(regImage));

  assert_high_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && !inRange) |-> (dataOut == '0));

endmodule

bind psg_regbus psg_regbus_chk #(
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busDir   (busDir),
  .busCtl   (busCtl),
  .dataIn   (dataIn),
  .dataOut  (dataOut),
  .dataOe   (dataOe),
  .curAddr  (curAddr),
  .regImage (regImage)
);

// File: tb/psg_regbus_tb_top.sv
`timescale 1ns/1ps
module psg_regbus_tb_top;

  localparam int DW = 8;
  localparam int NR = 14;

  logic            clk = 1'b0;
  logic            rstN = 1'b1;
  logic            busDir = 1'b0;
  logic            busCtl = 1'b0;
  logic [DW-1:0]   dataIn = '0;
  logic [DW-1:0]   dataOut;
  logic            dataOe;
  logic [DW*NR-1:0] regImage;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [DW-1:0] model [NR];

  always #4 clk = ~clk;

  psg_regbus dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .busDir   (busDir),
    .busCtl   (busCtl),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataOe   (dataOe),
    .regImage (regImage)
  );

  task automatic check(input string req, input logic [DW*NR-1:0] act, input logic [DW*NR-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW*NR-1:0] modelImage();
    logic [DW*NR-1:0] v;
    for (int k = 0; k < NR; k++) v[k*DW +: DW] = model[k];
    return v;
  endfunction

  task automatic clearModel();
    for (int k = 0; k < NR; k++) model[k] = '0;
  endtask

  // One bus cycle: drive at falling edge, hold across rising edge
  task automatic busCycle(input logic d, input logic c, input logic [DW-1:0] v);
    @(negedge clk);
    busDir = d; busCtl = c; dataIn = v;
    @(posedge clk);
  endtask

  task automatic writeReg(input logic [DW-1:0] a, input logic [DW-1:0] v);
    busCycle(0, 0, 8'h00);
    busCycle(1, 1, a);
    busCycle(0, 0, 8'h00);
    busCycle(1, 0, v);
    busCycle(0, 0, 8'h00);
  endtask

  task automatic readCur(output logic [DW-1:0] v, output logic oe);
    @(negedge clk);
    busDir = 0; busCtl = 1; dataIn = 8'hA5;
    #1;
    v = dataOut; oe = dataOe;
    @(posedge clk);
    busCycle(0, 0, 8'h00);
  endtask

  task automatic readReg(input logic [DW-1:0] a, output logic [DW-1:0] v);
    logic oe;
    busCycle(1, 1, a);
    busCycle(0, 0, 8'h00);
    readCur(v, oe);
  endtask

  task automatic testReset();
    logic [DW-1:0] v;
    @(negedge clk);
    check("R1 image in reset", regImage, '0);
    check("R1 oe in reset", {111'b0, dataOe}, '0);
    @(negedge clk); rstN = 1'b1;
    clearModel();
    for (int k = 0; k < NR; k++) begin
      readReg(k[DW-1:0], v);
      check("R7 unwritten reads zero", {104'b0, v}, '0);
    end
  endtask

  task automatic testProgram();
    logic [DW-1:0] v;
    writeReg(8'd7, 8'h38);  model[7] = 8'h38;
    @(negedge clk); check("R4 mixer write", regImage, modelImage());
    writeReg(8'd10, 8'h0C); model[10] = 8'h0C;
    @(negedge clk); check("R9 amplitude only", regImage, modelImage());
    writeReg(8'd4, 8'h51);  model[4] = 8'h51;
    @(negedge clk); check("R9 fine period only", regImage, modelImage());
    writeReg(8'd0, 8'hFF);  model[0] = 8'hFF;
    writeReg(8'd13, 8'h01); model[13] = 8'h01;
    @(negedge clk); check("R4 edge registers", regImage, modelImage());
    for (int k = 0; k < NR; k++) begin
      readReg(k[DW-1:0], v);
      check("R7 readback", {104'b0, v}, {104'b0, model[k]});
    end
  endtask

  task automatic testRepeat();
    logic [DW-1:0] v;
    logic oe;
    busCycle(1, 1, 8'd5);
    busCycle(0, 0, 8'h00);
    busCycle(1, 0, 8'h50);
    busCycle(1, 0, 8'h32);
    busCycle(0, 0, 8'h00);
    busCycle(1, 0, 8'h3C);
    busCycle(0, 0, 8'h00);
    model[5] = 8'h3C;
    @(negedge clk); check("R5 repeated writes", regImage, modelImage());
    readCur(v, oe);
    check("R2 address held over writes", {104'b0, v}, {104'b0, model[5]});
  endtask

  task automatic testBadLatch();
    logic [DW-1:0] v;
    logic oe;
    busCycle(1, 1, 8'd2);
    busCycle(1, 1, 8'h25);
    busCycle(0, 0, 8'h00);
    busCycle(1, 0, 8'h99);
    busCycle(0, 0, 8'h00);
    model[2] = 8'h99;
    @(negedge clk); check("R3 bad latch ignored", regImage, modelImage());
    busCycle(1, 1, 8'hF7);
    readCur(v, oe);
    check("R3 bad latch keeps number", {104'b0, v}, {104'b0, model[2]});
  endtask

  task automatic testHighAddr();
    logic [DW-1:0] v;
    writeReg(8'd14, 8'hAA);
    @(negedge clk); check("R8 write to 14 ignored", regImage, modelImage());
    writeReg(8'd15, 8'h55);
    @(negedge clk); check("R8 write to 15 ignored", regImage, modelImage());
    readReg(8'd14, v);
    check("R8 read 14 zero", {104'b0, v}, '0);
    readReg(8'd15, v);
    check("R8 read 15 zero", {104'b0, v}, '0);
  endtask

  task automatic testOe();
    logic [DW-1:0] v;
    logic oe;
    @(negedge clk); busDir = 0; busCtl = 0; #1;
    check("R6 oe idle", {111'b0, dataOe}, '0);
    @(negedge clk); busDir = 1; busCtl = 1; dataIn = 8'd7; #1;
    check("R6 oe latch", {111'b0, dataOe}, '0);
    @(negedge clk); busDir = 1; busCtl = 0; dataIn = 8'h38; #1;
    check("R6 oe write", {111'b0, dataOe}, '0);
    readCur(v, oe);
    check("R6 oe read", {111'b0, oe}, {111'b0, 1'b1});
    check("R2 read after write", {104'b0, v}, {104'b0, 8'h38});
  endtask

  task automatic testMidReset();
    @(negedge clk); rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    clearModel();
    check("R1 mid-run reset clears", regImage, '0);
    rstN = 1'b1;
    busCycle(1, 0, 8'h77);
    busCycle(0, 0, 8'h00);
    model[0] = 8'h77;
    @(negedge clk); check("R1 number cleared to 0", regImage, modelImage());
  endtask

  initial begin
    #3 rstN = 1'b0;
    @(posedge clk);
    testReset();
    testProgram();
    testRepeat();
    testBadLatch();
    testHighAddr();
    testOe();
    testMidReset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule